// File: doc/BRIEF.md
# Load/Store Target Decoder with Polled I/O Ports

This block sits on the load/store port of a processor and steers each access to one of two targets: the data memory or a small set of memory-mapped I/O registers. The most significant address bit alone picks the region. When that bit is clear, the access passes straight to memory and the memory read data comes back to the core. When it is set, memory is switched off, and the access is decoded against the I/O register addresses.

Two polled devices are modelled. The input device has a status word and a data word. A pulse on the device side loads a new value and raises a ready flag. Software polls the status word until bit 0 reads one, then loads the data word, and that load clears the flag. The output device also has a status word and a data word. Bit 0 of its status reads one while the device is idle. A store to its data word hands a value to the device and marks the device busy until the device acknowledges it. Every other address in the I/O region is a hole: it reads as zero and ignores stores.

Top module: `lsu_io_decode`

## Requirements
- R1: When cpu_addr[15] is 0, mem_en equals (cpu_rd or cpu_wr), mem_we equals cpu_wr, mem_addr equals cpu_addr, mem_wdata equals cpu_wdata, and cpu_rdata equals mem_rdata, all in the same cycle.
- R2: When cpu_addr[15] is 1, mem_en and mem_we are 0 whatever cpu_rd and cpu_wr are.
- R3: A load from the input status address (default 0x8000) returns bit 0 equal to the input ready flag, with all other bits zero, in the same cycle.
- R4: A cycle with dev_in_valid high captures dev_in_data and sets the input ready flag at that clock edge. A later load from the input data address (default 0x8004) returns the captured value.
- R5: A load from the input data address clears the ready flag at the clock edge. If dev_in_valid is high in the same cycle, the flag stays set and the new value is captured. Presenting that address with cpu_rd low leaves the flag unchanged.
- R6: A load from the output status address (default 0x8008) returns 1 in bit 0 when the output device is idle and 0 when it is busy, with all other bits zero.
- R7: A store to the output data address (default 0x800C) while the device is idle puts cpu_wdata on dev_out_data and raises dev_out_valid after the clock edge. dev_out_ack clears dev_out_valid at the next edge.
- R8: A store to the output data address while dev_out_valid is high is dropped, and dev_out_data keeps its value.
- R9: A load from any I/O address other than the four mapped ones returns 0. A store to such an address changes neither device's state. Any I/O-region cycle that is not a load of a mapped register drives cpu_rdata to 0.
- R10: After synchronous reset, the input ready flag is 0, dev_out_valid is 0 and dev_out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Load/store byte address |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data returned to the core |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Address to memory |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory |
| dev_in_valid | input | 1 | Input device presents a new value |
| dev_in_data | input | 32 | Input device value |
| dev_out_valid | output | 1 | Output value pending for the device |
| dev_out_data | output | 32 | Output value |
| dev_out_ack | input | 1 | Output device has consumed the value |

## Verification
The hardest cases to reach are the ones where two things meet at one clock edge. One is a load of the input data word arriving in the same cycle as a new device value. The other is a store arriving while an earlier output value is still pending. Neither can be reached with single accesses from idle. The bench first drives the device side into the ready or busy state. It then issues the colliding access on the very next cycle and reads the outcome back through the status and data addresses.

// File: rtl/lsu_io_pkg.sv
package lsu_io_pkg;

    // Target chosen for one load/store cycle.
    typedef enum logic [2:0] {
        TGT_MEM      = 3'd0,
        TGT_IN_STAT  = 3'd1,
        TGT_IN_DATA  = 3'd2,
        TGT_OUT_STAT = 3'd3,
        TGT_OUT_DATA = 3'd4,
        TGT_HOLE     = 3'd5
    } target_e;

    // Decoded access carried through the datapath.
    typedef struct packed {
        target_e tgt;
        logic    is_io;
        logic    rd;
        logic    wr;
    } access_t;

    // A target counts as a mapped I/O register when it is not memory and not a hole.
    function automatic logic is_mapped_io(input target_e t);
        return (t != TGT_MEM) && (t != TGT_HOLE);
    endfunction

endpackage

// File: rtl/lsu_io_addr_dec.sv
module lsu_io_addr_dec
    import lsu_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] IN_STAT_ADDR  = 16'h8000,
    parameter logic [ADDR_W-1:0] IN_DATA_ADDR  = 16'h8004,
    parameter logic [ADDR_W-1:0] OUT_STAT_ADDR = 16'h8008,
    parameter logic [ADDR_W-1:0] OUT_DATA_ADDR = 16'h800C
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output access_t           acc
);
    localparam int SEL_BIT = ADDR_W - 1;

    always_comb begin
        acc.rd    = rd;
        acc.wr    = wr;
        acc.is_io = addr[SEL_BIT];
        if (!addr[SEL_BIT])
            acc.tgt = TGT_MEM;
        else if (addr == IN_STAT_ADDR)
            acc.tgt = TGT_IN_STAT;
        else if (addr == IN_DATA_ADDR)
            acc.tgt = TGT_IN_DATA;
        else if (addr == OUT_STAT_ADDR)
            acc.tgt = TGT_OUT_STAT;
        else if (addr == OUT_DATA_ADDR)
            acc.tgt = TGT_OUT_DATA;
        else
            acc.tgt = TGT_HOLE;
    end
endmodule

// File: rtl/lsu_io_in_port.sv
module lsu_io_in_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              ready,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            data  <= '0;
        end else if (dev_valid) begin
            // A new value wins over a concurrent read of the old one.
            ready <= 1'b1;
            data  <= dev_data;
        end else if (take) begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/lsu_io_out_port.sv
module lsu_io_out_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic              busy,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            data <= '0;
        end else if (put && !busy) begin
            busy <= 1'b1;
            data <= wdata;
        end else if (ack) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/lsu_io_decode.sv
module lsu_io_decode
    import lsu_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] IN_STAT_ADDR  = 16'h8000,
    parameter logic [ADDR_W-1:0] IN_DATA_ADDR  = 16'h8004,
    parameter logic [ADDR_W-1:0] OUT_STAT_ADDR = 16'h8008,
    parameter logic [ADDR_W-1:0] OUT_DATA_ADDR = 16'h800C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ack
);
    localparam int PAD_W = DATA_W - 1;

    access_t           acc;
    logic              in_rdy;
    logic [DATA_W-1:0] in_word;
    logic              take_in;
    logic              put_out;

    lsu_io_addr_dec #(
        .ADDR_W       (ADDR_W),
        .IN_STAT_ADDR (IN_STAT_ADDR),
        .IN_DATA_ADDR (IN_DATA_ADDR),
        .OUT_STAT_ADDR(OUT_STAT_ADDR),
        .OUT_DATA_ADDR(OUT_DATA_ADDR)
    ) u_dec (
        .addr(cpu_addr),
        .rd  (cpu_rd),
        .wr  (cpu_wr),
        .acc (acc)
    );

    assign take_in = acc.rd && (acc.tgt == TGT_IN_DATA);
    assign put_out = acc.wr && (acc.tgt == TGT_OUT_DATA);

    lsu_io_in_port #(.DATA_W(DATA_W)) u_in (
        .clk      (clk),
        .rst      (rst),
        .take     (take_in),
        .dev_valid(dev_in_valid),
        .dev_data (dev_in_data),
        .ready    (in_rdy),
        .data     (in_word)
    );

    lsu_io_out_port #(.DATA_W(DATA_W)) u_out (
        .clk  (clk),
        .rst  (rst),
        .put  (put_out),
        .wdata(cpu_wdata),
        .ack  (dev_out_ack),
        .busy (dev_out_valid),
        .data (dev_out_data)
    );

    // Memory side: the same address and write data always reach memory.
    // The region bit gates the enables.
    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;
    assign mem_en    = !acc.is_io && (acc.rd || acc.wr);
    assign mem_we    = !acc.is_io && acc.wr;

    // Read-return multiplexer, selected by the decoded target.
    always_comb begin
        cpu_rdata = '0;
        if (!acc.is_io) begin
            cpu_rdata = mem_rdata;
        end else if (acc.rd && is_mapped_io(acc.tgt)) begin
            unique case (acc.tgt)
                TGT_IN_STAT:  cpu_rdata = {{PAD_W{1'b0}}, in_rdy};
                TGT_IN_DATA:  cpu_rdata = in_word;
                TGT_OUT_STAT: cpu_rdata = {{PAD_W{1'b0}}, !dev_out_valid};
                default:      cpu_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsu_io_decode_chk.sv
module lsu_io_decode_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] IN_STAT_ADDR  = 16'h8000,
    parameter logic [ADDR_W-1:0] IN_DATA_ADDR  = 16'h8004,
    parameter logic [ADDR_W-1:0] OUT_STAT_ADDR = 16'h8008,
    parameter logic [ADDR_W-1:0] OUT_DATA_ADDR = 16'h800C
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_en,
    input logic              mem_we,
    input logic              in_rdy,
    input logic              dev_in_valid,
    input logic              dev_out_valid,
    input logic [DATA_W-1:0] dev_out_data,
    input logic              dev_out_ack
);
    logic io_sel, hole;
    assign io_sel = cpu_addr[ADDR_W-1];
    assign hole   = io_sel && (cpu_addr != IN_STAT_ADDR) && (cpu_addr != IN_DATA_ADDR)
                    && (cpu_addr != OUT_STAT_ADDR) && (cpu_addr != OUT_DATA_ADDR);

    a_r1_store_writes_mem: assert property (@(posedge clk) disable iff (rst)
        (!io_sel && cpu_wr) |-> (mem_en && mem_we));

    a_r2_mem_off_for_io: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (!mem_en && !mem_we));

    a_r4_valid_sets_ready: assert property (@(posedge clk) disable iff (rst)
        dev_in_valid |=> in_rdy);

    a_r5_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == IN_DATA_ADDR && !dev_in_valid) |=> !in_rdy);

    a_r7_store_captured: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == OUT_DATA_ADDR && !dev_out_valid)
            |=> (dev_out_valid && dev_out_data == $past(cpu_wdata)));

    a_r8_busy_holds_data: assert property (@(posedge clk) disable iff (rst)
        dev_out_valid |=> $stable(dev_out_data));

    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && hole) |-> (cpu_rdata == '0));

    a_r7_ack_releases: assert property (@(posedge clk) disable iff (rst)
        (dev_out_valid && dev_out_ack) |=> !dev_out_valid);
endmodule

bind lsu_io_decode lsu_io_decode_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .IN_STAT_ADDR (IN_STAT_ADDR),
    .IN_DATA_ADDR (IN_DATA_ADDR),
    .OUT_STAT_ADDR(OUT_STAT_ADDR),
    .OUT_DATA_ADDR(OUT_DATA_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .in_rdy       (in_rdy),
    .dev_in_valid (dev_in_valid),
    .dev_out_valid(dev_out_valid),
    .dev_out_data (dev_out_data),
    .dev_out_ack  (dev_out_ack)
);

// File: tb/sim_lsu_io_decode.sv
module sim_lsu_io_decode;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        dev_in_valid;
    logic [31:0] dev_in_data;
    logic        dev_out_valid;
    logic [31:0] dev_out_data;
    logic        dev_out_ack;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    lsu_io_decode u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ack(dev_out_ack)
    );

    // Vector fields: rd, wr, addr, wdata, mem_rdata, exp mem_en, exp mem_we, exp cpu_rdata
    localparam int NV = 10;
    localparam logic [115:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0000, 32'h0000_0011, 32'hA5A5_5A5A, 1'b1, 1'b0, 32'hA5A5_5A5A}, // R1 load
        {1'b0, 1'b1, 16'h7FFC, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}, // R1 store
        {1'b1, 1'b0, 16'h7FFF, 32'h0000_0000, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'hDEAD_BEEF}, // R1 top of mem
        {1'b0, 1'b0, 16'h0100, 32'h0000_0000, 32'h0BAD_F00D, 1'b0, 1'b0, 32'h0BAD_F00D}, // R1 idle
        {1'b1, 1'b0, 16'h8010, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000}, // R2 R9 hole load
        {1'b0, 1'b1, 16'hFFFC, 32'h7777_7777, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_0000}, // R2 R9 hole store
        {1'b1, 1'b1, 16'h8004, 32'h0000_0000, 32'h1111_1111, 1'b0, 1'b0, 32'h0000_0000}, // R2 both strobes
        {1'b1, 1'b0, 16'h8002, 32'h0000_0000, 32'h2222_2222, 1'b0, 1'b0, 32'h0000_0000}, // R9 misaligned
        {1'b1, 1'b0, 16'h8000, 32'h0000_0000, 32'h3333_3333, 1'b0, 1'b0, 32'h0000_0000}, // R3 not ready
        {1'b1, 1'b0, 16'h8008, 32'h0000_0000, 32'h4444_4444, 1'b0, 1'b0, 32'h0000_0001}  // R6 idle
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        cpu_addr = 16'h0000; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
        dev_in_valid = 1'b0; dev_out_ack = 1'b0;
    endtask

    // Let one clock edge pass, then return to the falling edge to drive and sample.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [15:0] a, input logic [31:0] exp, input string req);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        chk(cpu_rdata == exp, req, cpu_rdata, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_bus();
        mem_rdata = '0; dev_in_data = '0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(dev_out_valid == 1'b0, "R10 out_valid", {31'b0, dev_out_valid}, 32'd0);
        chk(dev_out_data == '0, "R10 out_data", dev_out_data, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [115:0] v;
            v = VEC[i];
            cpu_rd = v[115]; cpu_wr = v[114]; cpu_addr = v[113:98];
            cpu_wdata = v[97:66]; mem_rdata = v[65:34];
            #1;
            chk(mem_en == v[33], "R1 R2 mem_en", {31'b0, mem_en}, {31'b0, v[33]});
            chk(mem_we == v[32], "R1 R2 mem_we", {31'b0, mem_we}, {31'b0, v[32]});
            chk(cpu_rdata == v[31:0], "R1 R9 rdata", cpu_rdata, v[31:0]);
            chk(mem_addr == cpu_addr && mem_wdata == cpu_wdata, "R1 passthrough",
                {mem_addr, 16'h0}, {cpu_addr, 16'h0});
            tick();
        end
        idle_bus();
        tick();
        // R9: hole store in the table left both devices untouched
        do_load(16'h8000, 32'd0, "R9 in status");
        do_load(16'h8008, 32'd1, "R9 out status");
        chk(dev_out_data == '0, "R9 out data", dev_out_data, 32'd0);

        // R4: device value arrives
        idle_bus();
        dev_in_valid = 1'b1; dev_in_data = 32'hCAFE_0001;
        tick();
        dev_in_valid = 1'b0;
        do_load(16'h8000, 32'd1, "R3 R4 ready");
        do_load(16'h8004, 32'hCAFE_0001, "R4 data");
        tick();
        // R5: the load above cleared the flag
        do_load(16'h8000, 32'd0, "R5 cleared");

        // R5: address without rd leaves the flag
        idle_bus();
        dev_in_valid = 1'b1; dev_in_data = 32'hCAFE_0002;
        tick();
        dev_in_valid = 1'b0; cpu_addr = 16'h8004; cpu_rd = 1'b0;
        tick();
        do_load(16'h8000, 32'd1, "R5 no rd keeps flag");
        // R5: read and new value in the same cycle
        cpu_addr = 16'h8004; cpu_rd = 1'b1;
        dev_in_valid = 1'b1; dev_in_data = 32'hCAFE_0003;
        tick();
        dev_in_valid = 1'b0;
        do_load(16'h8000, 32'd1, "R5 collide flag");
        do_load(16'h8004, 32'hCAFE_0003, "R5 collide data");
        tick();
        idle_bus();

        // R7: store to the output data address
        cpu_addr = 16'h800C; cpu_wr = 1'b1; cpu_wdata = 32'h0000_0055;
        #1;
        chk(mem_en == 1'b0, "R2 io store mem off", {31'b0, mem_en}, 32'd0);
        tick();
        // R8: second store while still pending
        cpu_wdata = 32'h0000_0066;
        #1;
        chk(dev_out_valid == 1'b1, "R7 valid", {31'b0, dev_out_valid}, 32'd1);
        chk(dev_out_data == 32'h55, "R7 data", dev_out_data, 32'h55);
        tick();
        cpu_wr = 1'b0;
        chk(dev_out_data == 32'h55, "R8 dropped", dev_out_data, 32'h55);
        do_load(16'h8008, 32'd0, "R6 busy");
        cpu_rd = 1'b0;
        dev_out_ack = 1'b1;
        tick();
        dev_out_ack = 1'b0;
        #1;
        chk(dev_out_valid == 1'b0, "R7 ack", {31'b0, dev_out_valid}, 32'd0);
        do_load(16'h8008, 32'd1, "R6 idle again");
        idle_bus();

        // R10: reset from a loaded state
        cpu_addr = 16'h800C; cpu_wr = 1'b1; cpu_wdata = 32'h0000_0099;
        dev_in_valid = 1'b1; dev_in_data = 32'h1;
        tick();
        idle_bus();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        chk(dev_out_valid == 1'b0, "R10 out_valid", {31'b0, dev_out_valid}, 32'd0);
        chk(dev_out_data == '0, "R10 out_data", dev_out_data, 32'd0);
        do_load(16'h8000, 32'd0, "R10 in ready");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule